// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block holds the power mode of a small microcontroller and picks the next one. A sleep-instruction strobe, an interrupt request and four control bits drive it. The four bits are standby select, direct-transfer enable, low-speed-on and prescaler-source select. The bits are sampled on the clock edge where the strobe or the interrupt arrives. The block moves between six modes: high-speed, subactive (the CPU runs on the subclock), subsleep, watch, hardware standby and reset. Two pins sit above all of this. An active-low standby pin forces hardware standby, and an active-low reset pin forces reset. The standby pin wins when both are low.

From the registered mode the block derives three things: a main/sub clock select, a CPU-run enable and a clock-enable mask with one bit per module. In the three low-speed modes only the timer and watchdog modules, chosen by a parameter mask, keep their clocks. A sticky flag reports a nonzero clock-division field seen while in subactive mode. An edge that samples an input changes the mode register, and the outputs show the new mode in the following cycle.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While the standby pin is low on an edge, the mode becomes hardware standby (code 4), whatever the other inputs are.
- R2: With the standby pin high, a low reset pin on an edge gives mode reset (code 5). From hardware standby, the first edge with the standby pin high gives reset. From reset, an edge with the reset pin high gives high-speed (code 0).
- R3: In high-speed, a sleep strobe with standby select, direct transfer and prescaler select all 1 gives subactive (code 1).
- R4: In subactive, a sleep strobe with standby select 1, direct transfer 0 and prescaler select 1 gives watch (code 3).
- R5: In subactive, a sleep strobe with standby select 0, low-speed-on 1 and prescaler select 1 gives subsleep (code 2).
- R6: In subactive, a sleep strobe with standby select 1, direct transfer 1, low-speed-on 0 and prescaler select 1 gives high-speed.
- R7: In watch, an interrupt with low-speed-on 1 gives subactive. An interrupt with low-speed-on 0 leaves the mode at watch.
- R8: In subsleep, any interrupt gives subactive.
- R9: A sleep strobe whose bits match no rule above, and an interrupt outside watch and subsleep, leave the mode unchanged.
- R10: The CPU-run enable is 1 only in high-speed and subactive. The clock select is 1 (subclock) in subactive, subsleep and watch. The module mask is all ones in high-speed, equals the keep mask (default 0x000F) in the three low-speed modes, and is zero in hardware standby and reset.
- R11: The error flag is set on an edge where the mode is subactive and the division field is nonzero. It then stays set until the reset pin or the standby pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| res_n | input | 1 | Reset pin, active low, sampled on the clock |
| stby_n | input | 1 | Hardware-standby pin, active low, sampled on the clock |
| sleep_stb | input | 1 | One-cycle sleep-instruction strobe |
| irq | input | 1 | Interrupt request |
| sel_standby | input | 1 | Standby select control bit |
| direct_xfer | input | 1 | Direct-transfer enable control bit |
| low_speed_on | input | 1 | Low-speed-on control bit |
| presc_sub | input | 1 | Prescaler-source select control bit |
| clk_div | input | DIV_W | Clock-division field |
| mode_o | output | 3 | Current mode code |
| clk_sub_sel | output | 1 | 1 selects the subclock |
| cpu_run_en | output | 1 | CPU may execute |
| mod_clk_en | output | N_MOD | Per-module clock enables |
| cfg_err | output | 1 | Sticky division-field error |

## Verification
Directed sequences walk every defined arc. They also try the near misses: the same strobe in the wrong mode, direct-transfer-to-high-speed with low-speed-on set, and a watch interrupt with low-speed-on clear. These separate a correct decode from one that ignores a single bit. Standby and reset are pulsed together and separately, which exposes any swapped priority. Seeded random cycles then mix strobes, interrupts, arbitrary bit patterns and nonzero division values across all modes. Those cycles catch transitions that fire from the wrong source mode and error flags that fail to stick or to clear.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   typedef enum logic [2:0] {
      PM_HIGH     = 3'd0,
      PM_SUBACT   = 3'd1,
      PM_SUBSLEEP = 3'd2,
      PM_WATCH    = 3'd3,
      PM_HWSTBY   = 3'd4,
      PM_RESET    = 3'd5
   } pm_mode_e;

   typedef struct packed {
      logic sel_standby;
      logic direct_xfer;
      logic low_speed_on;
      logic presc_sub;
   } pm_ctl_t;

   function automatic logic pm_is_lowspeed(pm_mode_e m);
      return (m == PM_SUBACT) || (m == PM_SUBSLEEP) || (m == PM_WATCH);
   endfunction
endpackage

// File: rtl/pwr_next_mode.sv
module pwr_next_mode
   import pwr_mode_pkg::*;
(
   input  pm_mode_e cur_mode,
   input  logic     res_n,
   input  logic     stby_n,
   input  logic     sleep_stb,
   input  logic     irq,
   input  pm_ctl_t  ctl,
   output pm_mode_e nxt_mode
);
   logic to_subact_from_high;
   logic to_watch;
   logic to_subsleep;
   logic to_high_direct;
   logic wake_watch;

   always_comb begin
      to_subact_from_high = sleep_stb && ctl.sel_standby && ctl.direct_xfer && ctl.presc_sub;
      to_watch            = sleep_stb && ctl.sel_standby && !ctl.direct_xfer && ctl.presc_sub;
      to_subsleep         = sleep_stb && !ctl.sel_standby && ctl.low_speed_on && ctl.presc_sub;
      to_high_direct      = sleep_stb && ctl.sel_standby && ctl.direct_xfer &&
                            !ctl.low_speed_on && ctl.presc_sub;
      wake_watch          = irq && ctl.low_speed_on;
   end

   always_comb begin
      nxt_mode = cur_mode;
      if (!stby_n) begin
         nxt_mode = PM_HWSTBY;
      end else if (cur_mode == PM_HWSTBY || !res_n) begin
         nxt_mode = PM_RESET;
      end else begin
         unique case (cur_mode)
            PM_RESET:    nxt_mode = PM_HIGH;
            PM_HIGH:     if (to_subact_from_high) nxt_mode = PM_SUBACT;
            PM_SUBACT: begin
               if (to_watch)             nxt_mode = PM_WATCH;
               else if (to_subsleep)     nxt_mode = PM_SUBSLEEP;
               else if (to_high_direct)  nxt_mode = PM_HIGH;
            end
            PM_WATCH:    if (wake_watch) nxt_mode = PM_SUBACT;
            PM_SUBSLEEP: if (irq) nxt_mode = PM_SUBACT;
            default:     nxt_mode = PM_RESET;
         endcase
      end
   end
endmodule

// File: rtl/pwr_clk_decode.sv
module pwr_clk_decode
   import pwr_mode_pkg::*;
#(
   parameter int              N_MOD     = 16,
   parameter logic [N_MOD-1:0] KEEP_MASK = 16'h000F
)(
   input  pm_mode_e          mode,
   output logic              clk_sub_sel,
   output logic              cpu_run_en,
   output logic [N_MOD-1:0]  mod_clk_en
);
   logic full_run;
   logic low_speed;

   always_comb begin
      full_run    = (mode == PM_HIGH);
      low_speed   = pm_is_lowspeed(mode);
      clk_sub_sel = low_speed;
      cpu_run_en  = full_run || (mode == PM_SUBACT);
   end

   for (genvar gi = 0; gi < N_MOD; gi++) begin : g_mod_en
      if (KEEP_MASK[gi]) begin : g_keep
         assign mod_clk_en[gi] = full_run || low_speed;
      end else begin : g_gate
         assign mod_clk_en[gi] = full_run;
      end
   end
endmodule

// File: rtl/pwr_cfg_check.sv
module pwr_cfg_check
   import pwr_mode_pkg::*;
#(
   parameter int DIV_W = 3
)(
   input  logic             clk,
   input  logic             res_n,
   input  logic             stby_n,
   input  pm_mode_e         mode,
   input  logic [DIV_W-1:0] clk_div,
   output logic             cfg_err
);
   logic err_q;

   always_ff @(posedge clk) begin
      if (!res_n || !stby_n) begin
         err_q <= 1'b0;
      end else if (mode == PM_SUBACT && clk_div != '0) begin
         err_q <= 1'b1;
      end
   end

   assign cfg_err = err_q;

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!res_n || !stby_n)
      err_q |=> err_q);
   a_r11_err_set: assert property (@(posedge clk) disable iff (!res_n || !stby_n)
      (mode == PM_SUBACT && clk_div != '0) |=> err_q);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int               N_MOD     = 16,
   parameter int               DIV_W     = 3,
   parameter logic [N_MOD-1:0] KEEP_MASK = 16'h000F
)(
   input  logic             clk,
   input  logic             res_n,
   input  logic             stby_n,
   input  logic             sleep_stb,
   input  logic             irq,
   input  logic             sel_standby,
   input  logic             direct_xfer,
   input  logic             low_speed_on,
   input  logic             presc_sub,
   input  logic [DIV_W-1:0] clk_div,
   output logic [2:0]       mode_o,
   output logic             clk_sub_sel,
   output logic             cpu_run_en,
   output logic [N_MOD-1:0] mod_clk_en,
   output logic             cfg_err
);
   localparam int MAX_MOD = 64;

   if (N_MOD < 1 || N_MOD > MAX_MOD) begin : g_bad_nmod
      $error("pwr_mode_ctrl: N_MOD out of range");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("pwr_mode_ctrl: DIV_W must be positive");
   end

   pm_ctl_t  ctl;
   pm_mode_e mode_q;
   pm_mode_e mode_d;

   assign ctl = '{sel_standby: sel_standby, direct_xfer: direct_xfer,
                  low_speed_on: low_speed_on, presc_sub: presc_sub};

   pwr_next_mode u_next (
      .cur_mode  (mode_q),
      .res_n     (res_n),
      .stby_n    (stby_n),
      .sleep_stb (sleep_stb),
      .irq       (irq),
      .ctl       (ctl),
      .nxt_mode  (mode_d)
   );

   always_ff @(posedge clk) begin
      mode_q <= mode_d;
   end

   assign mode_o = mode_q;

   pwr_clk_decode #(.N_MOD(N_MOD), .KEEP_MASK(KEEP_MASK)) u_dec (
      .mode        (mode_q),
      .clk_sub_sel (clk_sub_sel),
      .cpu_run_en  (cpu_run_en),
      .mod_clk_en  (mod_clk_en)
   );

   pwr_cfg_check #(.DIV_W(DIV_W)) u_cfg (
      .clk     (clk),
      .res_n   (res_n),
      .stby_n  (stby_n),
      .mode    (mode_q),
      .clk_div (clk_div),
      .cfg_err (cfg_err)
   );

   a_r1_standby_wins: assert property (@(posedge clk)
      !stby_n |=> mode_o == 3'd4);
   a_r2_reset_pin: assert property (@(posedge clk)
      (stby_n && !res_n) |=> mode_o == 3'd5);
   a_r3_high_to_sub: assert property (@(posedge clk) disable iff (!res_n || !stby_n)
      (mode_o == 3'd0 && sleep_stb && sel_standby && direct_xfer && presc_sub)
      |=> mode_o == 3'd1);
   a_r8_subsleep_wake: assert property (@(posedge clk) disable iff (!res_n || !stby_n)
      (mode_o == 3'd2 && irq) |=> mode_o == 3'd1);
   a_r9_high_hold: assert property (@(posedge clk) disable iff (!res_n || !stby_n)
      (mode_o == 3'd0 && !(sleep_stb && sel_standby && direct_xfer && presc_sub))
      |=> mode_o == 3'd0);
   a_r10_run_vs_mask: assert property (@(posedge clk)
      cpu_run_en |-> (mod_clk_en != '0));
   a_r10_sub_no_full: assert property (@(posedge clk)
      clk_sub_sel |-> (mod_clk_en == KEEP_MASK));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
   localparam int N_MOD = 16;
   localparam int DIV_W = 3;
   localparam logic [N_MOD-1:0] KEEP = 16'h000F;
   localparam logic [2:0] M_HIGH = 3'd0, M_SUBA = 3'd1, M_SSLP = 3'd2,
                          M_WAT = 3'd3, M_HWS = 3'd4, M_RST = 3'd5;

   logic clk = 1'b0;
   logic res_n = 1'b0, stby_n = 1'b1, sleep_stb = 1'b0, irq = 1'b0;
   logic sel_standby = 1'b0, direct_xfer = 1'b0, low_speed_on = 1'b0, presc_sub = 1'b0;
   logic [DIV_W-1:0] clk_div = '0;
   logic [2:0] mode_o;
   logic clk_sub_sel, cpu_run_en, cfg_err;
   logic [N_MOD-1:0] mod_clk_en;

   int n_chk = 0, n_fail = 0;
   logic [2:0] exp_mode = M_RST;
   logic exp_err = 1'b0;
   string exp_tag = "R2";

   always #2 clk = ~clk;

   pwr_mode_ctrl u_dut (
      .clk(clk), .res_n(res_n), .stby_n(stby_n), .sleep_stb(sleep_stb), .irq(irq),
      .sel_standby(sel_standby), .direct_xfer(direct_xfer), .low_speed_on(low_speed_on),
      .presc_sub(presc_sub), .clk_div(clk_div), .mode_o(mode_o),
      .clk_sub_sel(clk_sub_sel), .cpu_run_en(cpu_run_en), .mod_clk_en(mod_clk_en),
      .cfg_err(cfg_err));

   function automatic logic [2:0] model_next(input logic [2:0] m, output string tag);
      tag = "R9";
      model_next = m;
      if (!stby_n) begin model_next = M_HWS; tag = "R1"; end
      else if (m == M_HWS || !res_n) begin model_next = M_RST; tag = "R2"; end
      else if (m == M_RST) begin model_next = M_HIGH; tag = "R2"; end
      else if (m == M_HIGH && sleep_stb && sel_standby && direct_xfer && presc_sub) begin
         model_next = M_SUBA; tag = "R3";
      end else if (m == M_SUBA && sleep_stb && sel_standby && !direct_xfer && presc_sub) begin
         model_next = M_WAT; tag = "R4";
      end else if (m == M_SUBA && sleep_stb && !sel_standby && low_speed_on && presc_sub) begin
         model_next = M_SSLP; tag = "R5";
      end else if (m == M_SUBA && sleep_stb && sel_standby && direct_xfer &&
                   !low_speed_on && presc_sub) begin
         model_next = M_HIGH; tag = "R6";
      end else if (m == M_WAT && irq) begin
         model_next = low_speed_on ? M_SUBA : M_WAT; tag = "R7";
      end else if (m == M_SSLP && irq) begin
         model_next = M_SUBA; tag = "R8";
      end
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // drive inputs at negedge, then check the resulting state at the next negedge
   task automatic cyc(input logic s, input logic i, input logic ss, input logic dt,
                      input logic ls, input logic ps, input logic [DIV_W-1:0] dv,
                      input logic rn, input logic sn);
      logic [2:0] nm;
      logic ne;
      string t;
      sleep_stb = s; irq = i; sel_standby = ss; direct_xfer = dt;
      low_speed_on = ls; presc_sub = ps; clk_div = dv; res_n = rn; stby_n = sn;
      nm = model_next(exp_mode, t);
      ne = (!rn || !sn) ? 1'b0 : (exp_err || (exp_mode == M_SUBA && dv != '0));
      exp_mode = nm; exp_err = ne; exp_tag = t;
      @(negedge clk);
      check(mode_o == exp_mode, exp_tag, "mode", 32'(mode_o), 32'(exp_mode));
      begin
         logic lo, run;
         logic [N_MOD-1:0] msk;
         lo  = (exp_mode == M_SUBA || exp_mode == M_SSLP || exp_mode == M_WAT);
         run = (exp_mode == M_HIGH || exp_mode == M_SUBA);
         msk = (exp_mode == M_HIGH) ? '1 : (lo ? KEEP : '0);
         check(clk_sub_sel == lo && cpu_run_en == run && mod_clk_en == msk, "R10",
               "clocks", {14'd0, clk_sub_sel, cpu_run_en, mod_clk_en},
               {14'd0, lo, run, msk});
      end
      check(cfg_err == exp_err, "R11", "cfg_err", 32'(cfg_err), 32'(exp_err));
   endtask

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      cyc(0,0, 0,0,0,0, 0, 0,1);            // R2 reset held
      cyc(0,0, 0,0,0,0, 0, 1,1);            // R2 release to high
      cyc(1,0, 1,1,0,0, 0, 1,1);            // R9 missing prescaler bit
      cyc(0,1, 0,0,1,0, 0, 1,1);            // R9 irq in high
      cyc(1,0, 1,1,0,1, 0, 1,1);            // R3
      cyc(0,0, 0,0,0,0, 3'd2, 1,1);         // R11 set
      cyc(0,0, 0,0,0,0, 0, 1,1);            // R11 stays
      cyc(1,0, 1,1,1,1, 0, 1,1);            // R9 direct with low-speed-on set
      cyc(1,0, 1,0,0,1, 0, 1,1);            // R4 to watch
      cyc(0,1, 0,0,0,0, 0, 1,1);            // R7 irq without low-speed-on
      cyc(0,1, 0,0,1,0, 0, 1,1);            // R7 wake
      cyc(1,0, 0,0,1,1, 0, 1,1);            // R5 to subsleep
      cyc(1,0, 1,1,0,1, 0, 1,1);            // R9 sleep in subsleep
      cyc(0,1, 0,0,0,0, 0, 1,1);            // R8
      cyc(1,0, 1,1,0,1, 0, 1,1);            // R6 to high
      cyc(0,0, 0,0,0,0, 0, 0,0);            // R1 both low
      cyc(0,0, 0,0,0,0, 0, 0,1);            // R2 standby left, reset held
      cyc(0,0, 0,0,0,0, 0, 1,0);            // R1 again
      cyc(0,0, 0,0,0,0, 0, 1,1);            // R2 hw standby to reset
      cyc(0,0, 0,0,0,0, 0, 1,1);            // R2 to high
      for (int k = 0; k < 3000; k++) begin
         cyc(($urandom % 3) == 0, ($urandom % 4) == 0,
             1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) != 0,
             (($urandom % 8) == 0) ? DIV_W'($urandom) : '0,
             ($urandom % 40) != 0, ($urandom % 40) != 0);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule